// File: doc/BRIEF.md
# Selectable M-Sequence Overlay Generator

This block scrambles (transmitter) or descrambles (receiver) data symbols with a pseudo-random overlay bit so that the spectrum stays white even when the payload is highly repetitive. One shared 10-bit linear feedback shift register produces any of three maximal-length sequences, of period 63, 511 or 1023. A 2-bit select picks the sequence or turns the overlay off.

The register moves one step per data symbol, not per clock. The symbol strobe marks each symbol, and the overlay bit for that symbol is present on the outputs during the strobe cycle. A burst-start strobe reloads the seed and latches the select value. A transmitter and a receiver that both see the burst start therefore stay in step without any synchronisation search.

Each symbol carries an in-phase bit and a quadrature bit, and one overlay bit covers both. The overlay is combined with the data by modulo-2 addition, so the same block removes the overlay that it applies.

Top module: `mseq_overlay`

## Requirements
- R1: After reset the latched mode is "off" and the register holds the all-ones seed. Until the first burst start, both outputs equal their inputs whatever the symbol strobe does.
- R2: A burst started with select 0 passes both data bits through unchanged on every symbol.
- R3: Select 1 applies the sequence s with s[0..5]=1 and s[j]=s[j-2]^s[j-3]^s[j-5]^s[j-6]. It has period 63 and holds 32 ones per period.
- R4: Select 2 applies the sequence s with s[0..8]=1 and s[j]=s[j-2]^s[j-3]^s[j-5]^s[j-9]. It has period 511 and holds 256 ones per period.
- R5: Select 3 applies the sequence s with s[0..9]=1 and s[j]=s[j-2]^s[j-3]^s[j-5]^s[j-10]. It has period 1023 and holds 512 ones per period.
- R6: A burst start reloads the seed. The k-th symbol strobe after it (counting from 0) uses s[k]. A symbol strobe in the same cycle as a burst start sees the old state on the outputs and does not advance the register.
- R7: The register advances exactly once per symbol strobe. In cycles without a strobe the overlay bit, and so the output for given data, stays the same.
- R8: The same overlay bit is XORed onto both the in-phase bit and the quadrature bit: dout_i = din_i ^ b and dout_q = din_q ^ b.
- R9: A change of select takes effect only at the next burst start. Changes in the middle of a burst do not alter the sequence being applied.
- R10: The register never reaches the all-zero state in its active bits. After exactly one period of symbols it returns to the seed, so symbol k+L uses the same bit as symbol k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| burst_start | input | 1 | Reload the seed and latch the select |
| sym_stb | input | 1 | One data symbol is present this cycle |
| sel | input | 2 | 0 off, 1 period 63, 2 period 511, 3 period 1023 |
| din_i | input | 1 | In-phase data bit |
| din_q | input | 1 | Quadrature data bit |
| dout_i | output | 1 | In-phase bit with the overlay applied |
| dout_q | output | 1 | Quadrature bit with the overlay applied |

## Verification
The bench builds the block with its default parameters: a 10-bit register and two data lanes. This keeps even the longest period, 1023 symbols, short enough to sweep every symbol of every sequence and a stretch past each wrap. The bench computes the expected bits from the recurrences with an array of its own and counts the ones per period. It places idle cycles, select changes inside a burst, and restarts that coincide with a symbol strobe inside these sweeps.

// File: rtl/ovl_pkg.sv
`timescale 1ns/1ps
package ovl_pkg;

  localparam int unsigned SR_W  = 10;
  localparam int unsigned CNT_W = 10;
  localparam int unsigned SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    OVL_OFF   = 2'd0,
    OVL_S63   = 2'd1,
    OVL_S511  = 2'd2,
    OVL_S1023 = 2'd3
  } ovl_sel_e;

  // register order (degree) used by a mode
  function automatic int unsigned sr_order(ovl_sel_e m);
    case (m)
      OVL_S63:  return 6;
      OVL_S511: return 9;
      default:  return SR_W;
    endcase
  endfunction

  // sequence period 2^n - 1
  function automatic logic [CNT_W-1:0] seq_period(ovl_sel_e m);
    return CNT_W'((1 << sr_order(m)) - 1);
  endfunction

  // mask of the bits that take part in the sequence
  function automatic logic [SR_W-1:0] seed_mask(ovl_sel_e m);
    return SR_W'((1 << sr_order(m)) - 1);
  endfunction

  // new bit: taps at n-2, n-3, n-5 and 0 relative to the oldest bit
  function automatic logic fb_bit(logic [SR_W-1:0] s, ovl_sel_e m);
    int unsigned n;
    n = sr_order(m);
    return s[n-2] ^ s[n-3] ^ s[n-5] ^ s[0];
  endfunction

  // one step: bits below n-1 shift down, bit n-1 takes feedback, upper bits hold
  function automatic logic [SR_W-1:0] sr_advance(logic [SR_W-1:0] s, ovl_sel_e m);
    logic [SR_W-1:0] r;
    logic [SR_W-1:0] sh;
    int unsigned     n;
    n  = sr_order(m);
    sh = s >> 1;
    r  = s;
    for (int unsigned i = 0; i < SR_W; i++) begin
      if (i + 1 < n)       r[i] = sh[i];
      else if (i + 1 == n) r[i] = fb_bit(s, m);
    end
    return r;
  endfunction

endpackage

// File: rtl/ovl_mode_reg.sv
`timescale 1ns/1ps
module ovl_mode_reg
  import ovl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEL_W-1:0] sel_in,
  output ovl_sel_e         mode_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mode_q <= OVL_OFF;
    else if (load) mode_q <= ovl_sel_e'(sel_in);
  end

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(mode_q));

  // R9
  mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (mode_q == ovl_sel_e'($past(sel_in))));

endmodule

// File: rtl/ovl_lfsr.sv
`timescale 1ns/1ps
module ovl_lfsr
  import ovl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     restart,
  input  logic     advance,
  input  ovl_sel_e mode,
  output logic     ovl_bit
);

  localparam logic [SR_W-1:0] SEED = {SR_W{1'b1}};

  logic [SR_W-1:0] state_q;
  logic [SR_W-1:0] state_nxt;
  logic [SR_W-1:0] active_bits;

  assign state_nxt   = sr_advance(state_q, mode);
  assign ovl_bit     = state_q[0];
  assign active_bits = state_q & seed_mask(mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= SEED;
    else if (restart) state_q <= SEED;
    else if (advance) state_q <= state_nxt;
  end

  // step counter kept for the period assertion
  logic [CNT_W-1:0] step_cnt_q;
  logic             period_wrap;

  assign period_wrap = advance && (step_cnt_q == seq_period(mode) - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           step_cnt_q <= '0;
    else if (restart)     step_cnt_q <= '0;
    else if (period_wrap) step_cnt_q <= '0;
    else if (advance)     step_cnt_q <= step_cnt_q + 1'b1;
  end

  // R6
  seed_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (state_q == SEED));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !advance) |=> $stable(state_q));

  // R7
  step_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && advance) |=> (state_q != $past(state_q)));

  // R10
  no_lockup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_bits != '0);

  // R10
  period_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period_wrap && !restart) |=> (active_bits == seed_mask(mode)));

endmodule

// File: rtl/ovl_mixer.sv
`timescale 1ns/1ps
module ovl_mixer #(
  parameter int unsigned LANES = 2
) (
  input  logic             en,
  input  logic             ovl_bit,
  input  logic [LANES-1:0] din,
  output logic [LANES-1:0] dout
);

  logic eff_bit;
  assign eff_bit = en & ovl_bit;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dout[g] = din[g] ^ eff_bit;
  end

endmodule

// File: rtl/mseq_overlay.sv
`timescale 1ns/1ps
module mseq_overlay
  import ovl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burst_start,
  input  logic             sym_stb,
  input  logic [SEL_W-1:0] sel,
  input  logic             din_i,
  input  logic             din_q,
  output logic             dout_i,
  output logic             dout_q
);

  localparam int unsigned LANES = 2;

  ovl_sel_e         mode_w;
  logic             step_w;
  logic             ovl_bit_w;
  logic             ovl_en_w;
  logic [LANES-1:0] din_w;
  logic [LANES-1:0] dout_w;

  assign step_w   = sym_stb & ~burst_start;
  assign ovl_en_w = (mode_w != OVL_OFF);
  assign din_w    = {din_q, din_i};
  assign dout_i   = dout_w[0];
  assign dout_q   = dout_w[1];

  ovl_mode_reg u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (burst_start),
    .sel_in (sel),
    .mode_q (mode_w)
  );

  ovl_lfsr u_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (burst_start),
    .advance (step_w),
    .mode    (mode_w),
    .ovl_bit (ovl_bit_w)
  );

  ovl_mixer #(.LANES(LANES)) u_mix (
    .en      (ovl_en_w),
    .ovl_bit (ovl_bit_w),
    .din     (din_w),
    .dout    (dout_w)
  );

  // R8
  lane_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_i ^ dout_q) == (din_i ^ din_q));

  // R2
  off_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_w == OVL_OFF) |-> (dout_i == din_i && dout_q == din_q));

endmodule

// File: tb/sim_mseq_overlay.sv
`timescale 1ns/1ps
module sim_mseq_overlay;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       burst_start = 1'b0;
  logic       sym_stb = 1'b0;
  logic [1:0] sel = 2'd0;
  logic       din_i = 1'b0;
  logic       din_q = 1'b0;
  logic       dout_i;
  logic       dout_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit expv [0:2047];

  always #2.5 clk = ~clk;

  mseq_overlay u0 (
    .clk(clk), .rst_n(rst_n), .burst_start(burst_start), .sym_stb(sym_stb),
    .sel(sel), .din_i(din_i), .din_q(din_q), .dout_i(dout_i), .dout_q(dout_q)
  );

  task automatic chk(input string tag, input int k, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s sym=%0d actual=%0b expected=%0b", tag, k, act, exp);
    end
  endtask

  function automatic string mode_tag(input int m);
    case (m)
      1: return "R3";
      2: return "R4";
      3: return "R5";
      default: return "R2";
    endcase
  endfunction

  function automatic int order_of(input int m);
    return (m == 1) ? 6 : (m == 2) ? 9 : 10;
  endfunction

  // expected overlay bits from the recurrence; zero for the off mode
  task automatic build(input int m);
    int n;
    n = order_of(m);
    for (int j = 0; j < 2048; j++) begin
      if (m == 0)     expv[j] = 1'b0;
      else if (j < n) expv[j] = 1'b1;
      else            expv[j] = expv[j-2] ^ expv[j-3] ^ expv[j-5] ^ expv[j-n];
    end
  endtask

  task automatic idle();
    @(negedge clk);
    burst_start = 1'b0; sym_stb = 1'b0; din_i = 1'b0; din_q = 1'b0;
  endtask

  task automatic start_burst(input int m);
    @(negedge clk);
    burst_start = 1'b1; sym_stb = 1'b0; sel = 2'(m);
    @(negedge clk);
    burst_start = 1'b0;
    sel = 2'(~m);  // R9: changed in the middle of the burst, must be ignored
  endtask

  // one symbol k; expected bit is expv[k]
  task automatic symbol(input string tag, input int k, input logic di, input logic dq);
    @(negedge clk);
    burst_start = 1'b0; sym_stb = 1'b1; din_i = di; din_q = dq;
    #1;
    chk(tag, k, dout_i, di ^ expv[k]);
    chk({tag, " R8 q"}, k, dout_q, dq ^ expv[k]);
  endtask

  task automatic run_mode(input int m, input int nsym);
    int ones;
    int per;
    string tag;
    per  = (1 << order_of(m)) - 1;
    tag  = mode_tag(m);
    ones = 0;
    build(m);
    start_burst(m);
    for (int k = 0; k < nsym; k++) begin
      logic di, dq;
      di = k[0];
      dq = k[1] ^ k[2];
      symbol((k >= per) ? {tag, " R10 wrap"} : tag, k, di, dq);
      if (k < per && (dout_i ^ di)) ones++;
      if (k % 7 == 3) begin
        // R7: idle cycle, no step; output shows the bit for the next symbol
        idle();
        #1;
        chk("R7 idle hold", k + 1, dout_i, expv[k+1]);
      end
    end
    if (m != 0) begin
      checks++;
      if (ones != (per + 1) / 2) begin
        errors++;
        $display("FAIL %s ones per period actual=%0d expected=%0d", tag, ones, (per + 1) / 2);
      end
    end
    idle();
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state, outputs follow inputs even with strobes and select set
    sel = 2'd3;
    #1;
    chk("R1 reset i", 0, dout_i, din_i);
    rst_n = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      sym_stb = 1'b1; din_i = k[0]; din_q = k[1];
      #1;
      chk("R1 no burst i", k, dout_i, k[0]);
      chk("R1 no burst q", k, dout_q, k[1]);
    end
    idle();

    run_mode(0, 40);    // R2
    run_mode(1, 63 + 20);   // R3, R10
    run_mode(2, 511 + 12);  // R4, R10
    run_mode(3, 1023 + 12); // R5, R10

    // R6: restart mid-burst together with a symbol strobe
    build(1);
    start_burst(1);
    for (int k = 0; k < 10; k++) symbol("R6 pre", k, 1'b0, 1'b1);
    @(negedge clk);
    burst_start = 1'b1; sym_stb = 1'b1; sel = 2'd1; din_i = 1'b0; din_q = 1'b0;
    #1;
    chk("R6 coincident old state", 10, dout_i, expv[10]);
    for (int k = 0; k < 12; k++) symbol("R6 restart", k, 1'b0, 1'b0);
    idle();

    // R9: switch to the 1023 sequence at the next burst, then back to off
    build(3);
    start_burst(3);
    for (int k = 0; k < 20; k++) symbol("R9 new mode", k, k[0], 1'b0);
    build(0);
    start_burst(0);
    for (int k = 0; k < 10; k++) symbol("R9 off again", k, 1'b1, 1'b0);
    idle();

    // R1: reset in the middle of a burst returns to pass-through
    build(2);
    start_burst(2);
    for (int k = 0; k < 5; k++) symbol("R4 pre reset", k, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b0; sym_stb = 1'b0;
    #1;
    chk("R1 mid reset i", 0, dout_i, 1'b0);
    @(negedge clk);
    rst_n = 1'b1; sym_stb = 1'b1; din_i = 1'b1; din_q = 1'b0;
    #1;
    chk("R1 after reset i", 0, dout_i, 1'b1);
    chk("R1 after reset q", 0, dout_q, 1'b0);
    idle();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule